// File: doc/BRIEF.md
# LPC I/O Cycle Target

This block is the target side of a Low Pin Count bus port. It watches the active-low frame strobe and the four shared address/data lines, all synchronous to the bus clock. It recognises I/O read and I/O write cycles and checks the 16-bit port address against a window that can be enabled. A hit is handed to a local register port as a one-clock strobe. A write strobe carries the address and the data byte. A read strobe fetches a byte, which the block then returns on the bus inside the proper handshake.

Every other cycle type is dropped: the block goes back to idle and does not touch the lines. This covers memory, DMA and firmware cycles. A cycle aimed outside the window is followed to its end but never answered. A power-down input shuts the port at once. It removes the output enable in the same clock and sends the state machine to idle.

The window is an aligned block of 2^WIN_LOG2 ports. It is selected by the upper address bits on `win_page`. The local port must return read data on `reg_rdata` in the clock after `reg_rd`.

Top module: `lpc_io_target`

## Requirements
- R1: While the bus reset is low, and until a new cycle starts after it, `lad_oe`, `reg_wr` and `reg_rd` are all 0.
- R2: A cycle starts on a clock where `lframe_n` is 0 and `lad_in` is 4'b0000. If such a start nibble appears while a cycle is in progress, the old cycle is dropped and the new one begins.
- R3: The nibble after the start nibble is the cycle type. Bits [3:2]=00 select I/O, and bit 1 gives the direction: 4'b0000 is a read and 4'b0010 is a write. For any other type the block returns to idle and produces no strobe and no drive.
- R4: The address is taken from the next four nibbles, most significant nibble first. A cycle hits when `win_en` is 1 and address bits [15:WIN_LOG2] equal `win_page`.
- R5: On a write, the two data nibbles follow the address, low nibble first. For a hit, `reg_wr` pulses for exactly one clock during the first of the host's two turnaround clocks, with `reg_addr` and `reg_wdata` valid. Two clocks later the block drives 4'b0000 (ready).
- R6: On a read hit, `reg_rd` pulses for one clock during the first host turnaround clock, and `reg_rdata` is sampled at the end of the second. The block then drives 4'b0000, then the data's low nibble, then its high nibble.
- R7: After the ready nibble (and the read data, on a read), the block drives 4'b1111 for one clock and then releases the lines. `lad_oe` is 1 only in the ready, read-data and first target-turnaround clocks.
- R8: A cycle that misses the window, or any cycle while `win_en` is 0, produces no strobe and never sets `lad_oe`.
- R9: While `pwr_down` is 1, `lad_oe` is 0 in that same clock and the state machine is idle in the next one. After `pwr_down` returns to 0, the next cycle is served normally.
- R10: A clock with `lframe_n` at 0 and `lad_in` not 4'b0000 ends any cycle in progress. No drive follows from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Bus clock |
| lreset_n | input | 1 | Bus reset, active low; asserted asynchronously, released synchronously inside |
| lframe_n | input | 1 | Frame strobe, active low |
| lad_in | input | 4 | Address/data lines as seen by the receiver |
| lad_out | output | 4 | Nibble to drive onto the address/data lines |
| lad_oe | output | 1 | Output enable for `lad_out` |
| pwr_down | input | 1 | Shuts the port down while 1 |
| win_en | input | 1 | Enables the address window |
| win_page | input | ADDR_W-WIN_LOG2 | Upper address bits that select the window |
| reg_wr | output | 1 | One-clock write strobe to the local register port |
| reg_rd | output | 1 | One-clock read strobe to the local register port |
| reg_addr | output | ADDR_W | Decoded I/O address |
| reg_wdata | output | DATA_W | Write data byte |
| reg_rdata | input | DATA_W | Read data from the local port, valid the clock after `reg_rd` |

## Verification
The assertions are evaluated on every clock, in any traffic. They cover the following: a rejected cycle type leads back to idle, power-down reaches idle, `reg_wr` is a single-clock pulse, and `reg_rd` moves the cycle into its second turnaround clock. They also check that the enable drops after the first target-turnaround clock, that a frame abort never leads to drive, and that drive only ever follows a window hit. The exact clock positions of the ready nibble, the read-data nibble order and the restart of a cycle can only be shown by the bench's scenarios. The same holds for address decoding against the window, the write data reaching the right register, and service resuming after power-down.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_WDAT,
    ST_HTAR,
    ST_SYNC,
    ST_RDAT,
    ST_PTAR
  } lpc_st_e;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_TURN  = 4'b1111;

endpackage

// File: rtl/lpc_tgt_match.sv
module lpc_tgt_match #(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 4,
  localparam int PAGE_W  = ADDR_W - WIN_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  input  logic              enable,
  output logic              hit
);

  always_comb begin
    hit = enable && (addr[ADDR_W-1:WIN_LOG2] == page);
  end

endmodule

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_NIBS = ADDR_W / 4,
  localparam int DATA_NIBS = DATA_W / 4,
  localparam int CNT_W = $clog2(ADDR_NIBS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  input  logic              pwr_down,
  input  logic              hit_in,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] addr_nxt,
  output lpc_st_e           state,
  output logic [CNT_W-1:0]  cnt,
  output logic              hit_q,
  output logic [DATA_W-1:0] rd_byte,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata
);

  lpc_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dir_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rbyte_q;

  logic addr_last, wdat_last, rdat_last, turn_last;
  logic en_dir, en_addr, en_hit, en_wdat, en_rbyte;

  always_comb begin
    addr_nxt  = {addr_q[ADDR_W-5:0], lad_in};
    addr_last = (cnt_q == CNT_W'(ADDR_NIBS - 1));
    wdat_last = (cnt_q == CNT_W'(DATA_NIBS - 1));
    rdat_last = wdat_last;
    turn_last = (cnt_q == CNT_W'(1));
  end

  // next-state process
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: ;
      ST_CTYPE: begin
        cnt_d = '0;
        st_d  = (lad_in[3:2] == 2'b00) ? ST_ADDR : ST_IDLE;
      end
      ST_ADDR: begin
        if (addr_last) begin
          cnt_d = '0;
          st_d  = dir_wr_q ? ST_WDAT : ST_HTAR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WDAT: begin
        if (wdat_last) begin
          cnt_d = '0;
          st_d  = ST_HTAR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HTAR: begin
        if (turn_last) begin
          cnt_d = '0;
          st_d  = ST_SYNC;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SYNC: begin
        cnt_d = '0;
        st_d  = dir_wr_q ? ST_PTAR : ST_RDAT;
      end
      ST_RDAT: begin
        if (rdat_last) begin
          cnt_d = '0;
          st_d  = ST_PTAR;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PTAR: begin
        if (turn_last) begin
          cnt_d = '0;
          st_d  = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!lframe_n) begin
      cnt_d = '0;
      st_d  = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
    end
    if (pwr_down) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end
  end

  // clock enables for the datapath registers
  always_comb begin
    en_dir   = (st_q == ST_CTYPE);
    en_addr  = (st_q == ST_ADDR);
    en_hit   = (st_q == ST_ADDR) && addr_last;
    en_wdat  = (st_q == ST_WDAT);
    en_rbyte = (st_q == ST_HTAR) && turn_last && !dir_wr_q;
  end

  // state register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_wr_q <= 1'b0;
      addr_q   <= '0;
      hit_q    <= 1'b0;
      wdata_q  <= '0;
      rbyte_q  <= '0;
    end else begin
      if (en_dir)   dir_wr_q <= lad_in[1];
      if (en_addr)  addr_q   <= addr_nxt;
      if (en_hit)   hit_q    <= hit_in;
      if (en_wdat)  wdata_q  <= {lad_in, wdata_q[DATA_W-1:4]};
      if (en_rbyte) rbyte_q  <= reg_rdata;
    end
  end

  always_comb begin
    state     = st_q;
    cnt       = cnt_q;
    rd_byte   = rbyte_q;
    reg_addr  = addr_q;
    reg_wdata = wdata_q;
    reg_wr    = (st_q == ST_HTAR) && (cnt_q == '0) &&  dir_wr_q && hit_q && !pwr_down;
    reg_rd    = (st_q == ST_HTAR) && (cnt_q == '0) && !dir_wr_q && hit_q && !pwr_down;
  end

  // R3
  ctype_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CTYPE && lframe_n && lad_in[3:2] != 2'b00) |=> (st_q == ST_IDLE));

  // R9
  pd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (st_q == ST_IDLE));

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R6
  rd_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && lframe_n) |=> (st_q == ST_HTAR && cnt_q == CNT_W'(1)));

endmodule

// File: rtl/lpc_tgt_drv.sv
module lpc_tgt_drv
  import lpc_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lpc_st_e           state,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit_q,
  input  logic              pwr_down,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [3:0]        lad_out,
  output logic              lad_oe
);

  logic drive_phase;

  always_comb begin
    drive_phase = (state == ST_SYNC) || (state == ST_RDAT) ||
                  ((state == ST_PTAR) && (cnt == '0));
    lad_oe  = drive_phase && hit_q && !pwr_down;
    lad_out = NIB_READY;
    unique case (state)
      ST_RDAT: lad_out = rd_byte[4*int'(cnt) +: 4];
      ST_PTAR: lad_out = NIB_TURN;
      default: lad_out = NIB_READY;
    endcase
  end

  // R7
  turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PTAR && cnt == '0) |=> !lad_oe);

endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int WIN_LOG2 = 4,
  localparam int PAGE_W  = ADDR_W - WIN_LOG2,
  localparam int CNT_W   = $clog2(ADDR_W / 4)
) (
  input  logic              lclk,
  input  logic              lreset_n,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic              pwr_down,
  input  logic              win_en,
  input  logic [PAGE_W-1:0] win_page,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);

  logic [1:0]        rst_pipe;
  logic              rst_n;
  logic [ADDR_W-1:0] addr_nxt;
  logic              hit_now;
  lpc_st_e           state;
  logic [CNT_W-1:0]  cnt;
  logic              hit_q;
  logic [DATA_W-1:0] rd_byte;

  always_ff @(posedge lclk or negedge lreset_n) begin
    if (!lreset_n) rst_pipe <= 2'b00;
    else           rst_pipe <= {rst_pipe[0], 1'b1};
  end

  always_comb rst_n = rst_pipe[1];

  lpc_tgt_match #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_match (
    .addr   (addr_nxt),
    .page   (win_page),
    .enable (win_en),
    .hit    (hit_now)
  );

  lpc_tgt_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (lclk),
    .rst_n     (rst_n),
    .lframe_n  (lframe_n),
    .lad_in    (lad_in),
    .pwr_down  (pwr_down),
    .hit_in    (hit_now),
    .reg_rdata (reg_rdata),
    .addr_nxt  (addr_nxt),
    .state     (state),
    .cnt       (cnt),
    .hit_q     (hit_q),
    .rd_byte   (rd_byte),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
  );

  lpc_tgt_drv #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_drv (
    .clk      (lclk),
    .rst_n    (rst_n),
    .state    (state),
    .cnt      (cnt),
    .hit_q    (hit_q),
    .pwr_down (pwr_down),
    .rd_byte  (rd_byte),
    .lad_out  (lad_out),
    .lad_oe   (lad_oe)
  );

  // R8
  miss_quiet_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    lad_oe |-> hit_q);

  // R10
  frame_abort_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    (!lframe_n && lad_in != NIB_START) |=> !lad_oe);

endmodule

// File: tb/lpc_io_target_test.sv
module lpc_io_target_test;

  logic        lclk = 1'b0;
  logic        lreset_n, lframe_n, pwr_down, win_en;
  logic [3:0]  lad_in, lad_out;
  logic        lad_oe, reg_wr, reg_rd;
  logic [11:0] win_page;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;

  always #10 lclk = ~lclk;

  lpc_io_target uut (
    .lclk(lclk), .lreset_n(lreset_n), .lframe_n(lframe_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .pwr_down(pwr_down), .win_en(win_en),
    .win_page(win_page), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // local register port model
  logic [7:0] mem [0:15];
  logic [7:0] exp_mem [0:15];
  always @(posedge lclk) begin
    if (reg_wr) mem[reg_addr[3:0]] <= reg_wdata;
    if (reg_rd) reg_rdata <= mem[reg_addr[3:0]];
  end

  localparam int NS = 24;
  logic        h_fr [0:NS-1];
  logic [3:0]  h_nib [0:NS-1];
  logic        h_pd [0:NS-1];
  logic        o_oe [0:NS-1];
  logic        p_oe [0:NS-1];
  logic [3:0]  o_lad [0:NS-1];
  logic        o_wr [0:NS-1];
  logic        o_rd [0:NS-1];
  logic [15:0] o_addr [0:NS-1];
  logic [7:0]  o_wd [0:NS-1];

  int n_checks = 0;
  int n_fail = 0;

  // {write, expect hit, address, data}
  localparam logic [25:0] VEC [0:9] = '{
    {1'b1, 1'b1, 16'h0CA3, 8'h5A},
    {1'b1, 1'b1, 16'h0CAF, 8'hC3},
    {1'b0, 1'b1, 16'h0CA3, 8'h00},
    {1'b0, 1'b1, 16'h0CAF, 8'h00},
    {1'b1, 1'b0, 16'h0CB3, 8'h77},
    {1'b0, 1'b0, 16'h0CB3, 8'h00},
    {1'b1, 1'b1, 16'h0CA0, 8'hE1},
    {1'b0, 1'b1, 16'h0CA0, 8'h00},
    {1'b0, 1'b0, 16'h1CA3, 8'h00},
    {1'b0, 1'b1, 16'h0CA3, 8'h00}
  };

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear();
    for (int k = 0; k < NS; k++) begin
      h_fr[k] = 1'b1; h_nib[k] = 4'hF; h_pd[k] = 1'b0;
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge lclk);
      o_oe[k] = lad_oe; o_lad[k] = lad_out; o_wr[k] = reg_wr; o_rd[k] = reg_rd;
      o_addr[k] = reg_addr; o_wd[k] = reg_wdata;
      lframe_n = h_fr[k]; lad_in = h_nib[k]; pwr_down = h_pd[k];
      #1 p_oe[k] = lad_oe;
    end
    clear();
  endtask

  task automatic put_hdr(input int b, input logic [3:0] ctype, input logic [15:0] a);
    h_fr[b] = 1'b0; h_nib[b] = 4'h0;
    h_nib[b+1] = ctype;
    h_nib[b+2] = a[15:12]; h_nib[b+3] = a[11:8];
    h_nib[b+4] = a[7:4];   h_nib[b+5] = a[3:0];
  endtask

  task automatic put_write(input int b, input logic [15:0] a, input logic [7:0] d);
    put_hdr(b, 4'b0010, a);
    h_nib[b+6] = d[3:0]; h_nib[b+7] = d[7:4];
  endtask

  task automatic check_read(input int b, input logic [15:0] a, input logic [7:0] e);
    int early = 0;
    for (int k = 0; k < b + 8; k++) early += int'(o_oe[k]);
    chk("R7 no drive before ready nibble", early, 0);
    chk("R6 read strobe", o_rd[b+6], 1);
    chk("R4 read address", o_addr[b+6], a);
    chk("R6 read strobe single", o_rd[b+7], 0);
    chk("R6 ready nibble", {o_oe[b+8], o_lad[b+8]}, {1'b1, 4'h0});
    chk("R6 low data nibble", {o_oe[b+9], o_lad[b+9]}, {1'b1, e[3:0]});
    chk("R6 high data nibble", {o_oe[b+10], o_lad[b+10]}, {1'b1, e[7:4]});
    chk("R7 turnaround nibble", {o_oe[b+11], o_lad[b+11]}, {1'b1, 4'hF});
    chk("R7 release", {o_oe[b+12], o_oe[b+13]}, 2'b00);
  endtask

  task automatic check_write(input int b, input logic [15:0] a, input logic [7:0] d);
    int early = 0;
    for (int k = 0; k < b + 10; k++) early += int'(o_oe[k]);
    chk("R7 no drive before ready nibble", early, 0);
    chk("R5 write strobe", o_wr[b+8], 1);
    chk("R4 write address", o_addr[b+8], a);
    chk("R5 write data", o_wd[b+8], d);
    chk("R5 write strobe single", o_wr[b+9], 0);
    chk("R5 ready nibble", {o_oe[b+10], o_lad[b+10]}, {1'b1, 4'h0});
    chk("R7 turnaround nibble", {o_oe[b+11], o_lad[b+11]}, {1'b1, 4'hF});
    chk("R7 release", {o_oe[b+12], o_oe[b+13]}, 2'b00);
  endtask

  task automatic check_silent(input string req, input int n);
    int drv = 0;
    int stb = 0;
    for (int k = 0; k < n; k++) begin
      drv += int'(o_oe[k]);
      stb += int'(o_wr[k]) + int'(o_rd[k]);
    end
    chk({req, " no drive"}, drv, 0);
    chk({req, " no strobe"}, stb, 0);
  endtask

  initial begin
    repeat (100000) @(posedge lclk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    reg_rdata = 8'h00;
    lreset_n = 1'b0; lframe_n = 1'b1; lad_in = 4'hF; pwr_down = 1'b0;
    win_en = 1'b1; win_page = 12'h0CA;
    clear();
    repeat (3) @(negedge lclk);
    // R1: outputs quiet during reset
    chk("R1 reset outputs", {lad_oe, reg_wr, reg_rd}, 3'b000);
    lreset_n = 1'b1;
    repeat (4) @(negedge lclk);
    chk("R1 after reset outputs", {lad_oe, reg_wr, reg_rd}, 3'b000);

    // table walk
    for (int i = 0; i < 10; i++) begin
      logic        wr, hit;
      logic [15:0] a;
      logic [7:0]  d;
      {wr, hit, a, d} = VEC[i];
      if (wr) put_write(0, a, d);
      else    put_hdr(0, 4'b0000, a);
      run(14);
      if (!hit)    check_silent("R8 window miss", 14);
      else if (wr) begin check_write(0, a, d); exp_mem[a[3:0]] = d; end
      else         check_read(0, a, exp_mem[a[3:0]]);
    end

    // R3: memory read type is ignored, then an I/O read still works
    put_hdr(0, 4'b0100, 16'h0CA3);
    run(14);
    check_silent("R3 non-I/O type", 14);
    put_hdr(0, 4'b0000, 16'h0CA3);
    run(14);
    check_read(0, 16'h0CA3, exp_mem[3]);

    // R3: firmware-like type 4'b1101 also ignored
    put_hdr(0, 4'b1101, 16'h0CAF);
    run(14);
    check_silent("R3 other type", 14);

    // R2: restart with a start nibble in the middle of an address
    h_fr[0] = 1'b0; h_nib[0] = 4'h0; h_nib[1] = 4'h0; h_nib[2] = 4'h0; h_nib[3] = 4'hC;
    put_write(4, 16'h0CA5, 8'h96);
    run(18);
    begin
      int rds = 0;
      for (int k = 0; k < 18; k++) rds += int'(o_rd[k]);
      chk("R2 restarted read gives no strobe", rds, 0);
    end
    check_write(4, 16'h0CA5, 8'h96);
    exp_mem[5] = 8'h96;
    put_hdr(0, 4'b0000, 16'h0CA5);
    run(14);
    check_read(0, 16'h0CA5, 8'h96);

    // R10: frame abort on the last address nibble
    put_hdr(0, 4'b0000, 16'h0CA3);
    h_fr[5] = 1'b0; h_nib[5] = 4'hF;
    run(14);
    check_silent("R10 aborted read", 14);

    // R9: power-down during the ready nibble of a read
    put_hdr(0, 4'b0000, 16'h0CAF);
    h_pd[8] = 1'b1; h_pd[9] = 1'b1; h_pd[10] = 1'b1;
    run(14);
    begin
      int drv = 0;
      for (int k = 8; k < 14; k++) drv += int'(p_oe[k]);
      chk("R9 no drive during and after power-down", drv, 0);
    end
    put_hdr(0, 4'b0000, 16'h0CAF);
    run(14);
    check_read(0, 16'h0CAF, exp_mem[15]);

    // R8: window disabled
    win_en = 1'b0;
    put_write(0, 16'h0CA3, 8'h11);
    run(14);
    check_silent("R8 window disabled", 14);
    win_en = 1'b1;
    put_hdr(0, 4'b0000, 16'h0CA3);
    run(14);
    check_read(0, 16'h0CA3, exp_mem[3]);

    report();
  end

endmodule